// File: doc/BRIEF.md
# Stable Load Elimination Table

This block is a per-core, direct-mapped table that learns which static load instructions keep returning the same data from the same memory address. Once a load has shown that behaviour often enough, the table answers a rename-stage lookup on that load's PC with the remembered data. Later instances of the load can then skip execution entirely. There is no speculative guess that has to be checked afterwards.

Completed loads train the table with their PC, address, data and up to two source register ids. The table withdraws eligibility on three kinds of event: a write to one of the recorded source registers, a store that falls inside the recorded 8-byte block, and a coherence snoop that falls inside that block. A withdrawn entry keeps its data and address but must rebuild confidence through normal training before it can supply data again.

Top module: `sle_table`

## Requirements
- R1: After a synchronous reset, no lookup hits, whatever PC is presented.
- R2: A training event whose PC misses the table, or finds an invalid entry, allocates the entry with confidence 0. Each further training event with the same PC, exact address and exact data raises confidence by one, saturating at 3. The entry becomes eligible when confidence reaches 3, so the fourth identical completion in a row makes it eligible. Lookups before that miss.
- R3: A lookup on a valid, eligible entry whose tag matches the PC returns hit=1 in the same cycle, with the recorded data on `lk_data`. `lk_data` is zero on a miss.
- R4: A training event on a tagged entry with a different address or different data resets confidence to 0, clears eligibility and records the new address and data.
- R5: A register write whose id equals either valid source id of any valid entry resets that entry's confidence and eligibility. All entries are compared in the same cycle.
- R6: A store whose address agrees with the recorded address in bits 31..3 revokes the entry. A store to a different 8-byte block leaves it eligible.
- R7: A snoop whose address agrees with the recorded address in bits 31..3 revokes the entry in the same way as a store.
- R8: When a revocation hits the looked-up entry in the same cycle as the lookup, the lookup reports a miss.
- R9: A revoked entry keeps its address and data. Three further matching training events make it eligible again.
- R10: The index is PC bits 6..2 and the tag is PC bits 31..7. A lookup whose index matches but whose tag differs misses.
- R11: When training and revocation hit the same entry in the same cycle, the revocation wins: the entry ends with confidence 0 and is not eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | PC of the load being renamed |
| lk_hit | output | 1 | Load may be eliminated |
| lk_data | output | 64 | Recorded value for an eliminated load |
| tr_valid | input | 1 | Training event from a completed load |
| tr_pc | input | 32 | PC of the completed load |
| tr_addr | input | 32 | Address the load read |
| tr_data | input | 64 | Data the load returned |
| tr_src0_vld | input | 1 | First source register id is meaningful |
| tr_src0 | input | 5 | First source register id |
| tr_src1_vld | input | 1 | Second source register id is meaningful |
| tr_src1 | input | 5 | Second source register id |
| rw_valid | input | 1 | Architectural register write notification |
| rw_reg | input | 5 | Id of the written register |
| st_valid | input | 1 | Store address notification |
| st_addr | input | 32 | Store address |
| sn_valid | input | 1 | Coherence snoop notification |
| sn_addr | input | 32 | Snoop address |

## Verification
A stale eligible bit is the dangerous fault. It shows at the ports as a hit with old data on a lookup one cycle after the register write, store or snoop that should have revoked the entry. A same-cycle conflict shows as a hit in the revoking cycle itself. A confidence counter that advances too early or too late shows as a hit after the third identical completion, or as a miss after the fourth. Training faults that record the wrong address or data show as wrong `lk_data`, or as a retrain that completes too quickly after a mismatch. Each of these faults appears at the first lookup following the offending event.

// File: rtl/sle_pkg.sv
package sle_pkg;
    localparam int PC_W     = 32;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 64;
    localparam int REG_W    = 5;
    localparam int CONF_W   = 2;
    localparam int GRAN_LSB = 3;
    localparam int IDX_LSB  = 2;

    localparam logic [CONF_W-1:0] CONF_MAX = '1;

    typedef struct packed {
        logic              valid;
        logic              elig;
        logic [CONF_W-1:0] conf;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              s0_v;
        logic [REG_W-1:0]  s0;
        logic              s1_v;
        logic [REG_W-1:0]  s1;
    } sle_entry_t;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              s0_v;
        logic [REG_W-1:0]  s0;
        logic              s1_v;
        logic [REG_W-1:0]  s1;
    } sle_train_t;

    function automatic logic same_block(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:GRAN_LSB] == b[ADDR_W-1:GRAN_LSB];
    endfunction

    function automatic sle_entry_t withdraw(input sle_entry_t e);
        sle_entry_t r;
        r      = e;
        r.elig = 1'b0;
        r.conf = '0;
        return r;
    endfunction
endpackage

// File: rtl/sle_revoke_unit.sv
module sle_revoke_unit
    import sle_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  sle_entry_t               ent [ENTRIES],
    input  logic                     rw_valid,
    input  logic [REG_W-1:0]         rw_reg,
    input  logic                     st_valid,
    input  logic [ADDR_W-1:0]        st_addr,
    input  logic                     sn_valid,
    input  logic [ADDR_W-1:0]        sn_addr,
    output logic [ENTRIES-1:0]       revoke
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic reg_hit;
        logic mem_hit;
        always_comb begin
            reg_hit = rw_valid &&
                      ((ent[g].s0_v && ent[g].s0 == rw_reg) ||
                       (ent[g].s1_v && ent[g].s1 == rw_reg));
            mem_hit = (st_valid && same_block(ent[g].addr, st_addr)) ||
                      (sn_valid && same_block(ent[g].addr, sn_addr));
            revoke[g] = ent[g].valid && (reg_hit || mem_hit);
        end
    end
endmodule

// File: rtl/sle_train_next.sv
module sle_train_next
    import sle_pkg::*;
#(
    parameter int TAG_W = 25
) (
    input  sle_entry_t       cur,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic [TAG_W-1:0] tr_tag,
    input  sle_train_t       tr,
    output sle_entry_t       nxt,
    output logic [TAG_W-1:0] nxt_tag
);
    logic same_load;
    logic repeat_seen;

    always_comb begin
        same_load   = cur.valid && (cur_tag == tr_tag);
        repeat_seen = same_load && (cur.addr == tr.addr) && (cur.data == tr.data);

        nxt         = cur;
        nxt_tag     = tr_tag;
        nxt.valid   = 1'b1;
        nxt.s0_v    = tr.s0_v;
        nxt.s0      = tr.s0;
        nxt.s1_v    = tr.s1_v;
        nxt.s1      = tr.s1;

        if (repeat_seen) begin
            if (cur.conf != CONF_MAX) begin
                nxt.conf = cur.conf + 1'b1;
            end
            nxt.elig = (nxt.conf == CONF_MAX);
        end else begin
            nxt.addr = tr.addr;
            nxt.data = tr.data;
            nxt.conf = '0;
            nxt.elig = 1'b0;
        end
    end
endmodule

// File: rtl/sle_table.sv
module sle_table
    import sle_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              tr_valid,
    input  logic [PC_W-1:0]   tr_pc,
    input  logic [ADDR_W-1:0] tr_addr,
    input  logic [DATA_W-1:0] tr_data,
    input  logic              tr_src0_vld,
    input  logic [REG_W-1:0]  tr_src0,
    input  logic              tr_src1_vld,
    input  logic [REG_W-1:0]  tr_src1,
    input  logic              rw_valid,
    input  logic [REG_W-1:0]  rw_reg,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              sn_valid,
    input  logic [ADDR_W-1:0] sn_addr
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - IDX_LSB;

    sle_entry_t         tbl      [ENTRIES];
    sle_entry_t         tbl_nxt  [ENTRIES];
    logic [TAG_W-1:0]   tags     [ENTRIES];
    logic [TAG_W-1:0]   tags_nxt [ENTRIES];
    logic [ENTRIES-1:0] revoke_vec;
    logic [ENTRIES-1:0] elig_vec;

    logic [IDX_W-1:0]   lk_idx;
    logic [TAG_W-1:0]   lk_tag;
    logic [IDX_W-1:0]   tr_idx;
    logic [TAG_W-1:0]   tr_tag;
    sle_train_t         tr_pkt;
    sle_entry_t         tr_ent_nxt;
    logic [TAG_W-1:0]   tr_tag_nxt;
    sle_entry_t         lk_ent;

    assign lk_idx = lk_pc[IDX_LSB +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
    assign tr_idx = tr_pc[IDX_LSB +: IDX_W];
    assign tr_tag = tr_pc[PC_W-1 -: TAG_W];

    always_comb begin
        tr_pkt.pc   = tr_pc;
        tr_pkt.addr = tr_addr;
        tr_pkt.data = tr_data;
        tr_pkt.s0_v = tr_src0_vld;
        tr_pkt.s0   = tr_src0;
        tr_pkt.s1_v = tr_src1_vld;
        tr_pkt.s1   = tr_src1;
    end

    sle_revoke_unit #(.ENTRIES(ENTRIES)) u_revoke (
        .ent      (tbl),
        .rw_valid (rw_valid),
        .rw_reg   (rw_reg),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .sn_valid (sn_valid),
        .sn_addr  (sn_addr),
        .revoke   (revoke_vec)
    );

    sle_train_next #(.TAG_W(TAG_W)) u_train (
        .cur     (tbl[tr_idx]),
        .cur_tag (tags[tr_idx]),
        .tr_tag  (tr_tag),
        .tr      (tr_pkt),
        .nxt     (tr_ent_nxt),
        .nxt_tag (tr_tag_nxt)
    );

    // Lookup: same-cycle answer from registered state, revocation has priority.
    always_comb begin
        lk_ent  = tbl[lk_idx];
        lk_hit  = lk_valid && lk_ent.valid && lk_ent.elig &&
                  (tags[lk_idx] == lk_tag) && !revoke_vec[lk_idx];
        lk_data = lk_hit ? lk_ent.data : '0;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic trained;
        always_comb begin
            trained     = tr_valid && (tr_idx == IDX_W'(g));
            tbl_nxt[g]  = trained ? tr_ent_nxt : tbl[g];
            tags_nxt[g] = trained ? tr_tag_nxt : tags[g];
            if (revoke_vec[g]) begin
                tbl_nxt[g] = withdraw(tbl_nxt[g]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g]  <= '0;
                tags[g] <= '0;
            end else begin
                tbl[g]  <= tbl_nxt[g];
                tags[g] <= tags_nxt[g];
            end
        end

        assign elig_vec[g] = tbl[g].valid && tbl[g].elig;
    end
endmodule

// File: rtl/sle_table_chk.sv
module sle_table_chk
    import sle_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic [PC_W-1:0]    lk_pc,
    input logic               lk_hit,
    input logic               tr_valid,
    input logic [ENTRIES-1:0] elig_vec,
    input logic [ENTRIES-1:0] revoke_vec
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] chk_idx;
    assign chk_idx = lk_pc[IDX_LSB +: IDX_W];

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (elig_vec == '0 && !lk_hit));

    // R3
    hit_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_valid);

    // R2
    elig_only_by_training_chk: assert property (@(posedge clk) disable iff (rst)
        !tr_valid |=> ((elig_vec & ~$past(elig_vec)) == '0));

    // R11
    revoke_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|revoke_vec) |=> ((elig_vec & $past(revoke_vec)) == '0));

    // R8
    revoke_blocks_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> !revoke_vec[chk_idx]);
endmodule

bind sle_table sle_table_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .lk_pc      (lk_pc),
    .lk_hit     (lk_hit),
    .tr_valid   (tr_valid),
    .elig_vec   (elig_vec),
    .revoke_vec (revoke_vec)
);

// File: tb/sle_table_tb.sv
module sle_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 0;
    logic        rst = 1;
    logic        lk_valid = 0;
    logic [31:0] lk_pc = 0;
    logic        lk_hit;
    logic [63:0] lk_data;
    logic        tr_valid = 0;
    logic [31:0] tr_pc = 0;
    logic [31:0] tr_addr = 0;
    logic [63:0] tr_data = 0;
    logic        tr_src0_vld = 0;
    logic [4:0]  tr_src0 = 0;
    logic        tr_src1_vld = 0;
    logic [4:0]  tr_src1 = 0;
    logic        rw_valid = 0;
    logic [4:0]  rw_reg = 0;
    logic        st_valid = 0;
    logic [31:0] st_addr = 0;
    logic        sn_valid = 0;
    logic [31:0] sn_addr = 0;

    int checks = 0;
    int fails  = 0;

    // bench reference state
    logic        m_v   [N];
    logic        m_e   [N];
    int          m_c   [N];
    logic [24:0] m_tag [N];
    logic [31:0] m_a   [N];
    logic [63:0] m_d   [N];
    logic        m_s0v [N];
    logic [4:0]  m_s0  [N];
    logic        m_s1v [N];
    logic [4:0]  m_s1  [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    sle_table u_dut (.*);

    function automatic logic [4:0]  b_idx(input logic [31:0] pc); return pc[6:2];  endfunction
    function automatic logic [24:0] b_tag(input logic [31:0] pc); return pc[31:7]; endfunction

    function automatic logic m_rev(input int i);
        logic r;
        r = 0;
        if (rw_valid && ((m_s0v[i] && m_s0[i] == rw_reg) || (m_s1v[i] && m_s1[i] == rw_reg))) r = 1;
        if (st_valid && st_addr[31:3] == m_a[i][31:3]) r = 1;
        if (sn_valid && sn_addr[31:3] == m_a[i][31:3]) r = 1;
        return r && m_v[i];
    endfunction

    function automatic logic m_hit();
        int i;
        i = b_idx(lk_pc);
        return lk_valid && m_v[i] && m_e[i] && m_tag[i] == b_tag(lk_pc) && !m_rev(i);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_e[i] = 0; m_c[i] = 0; m_tag[i] = 0; m_a[i] = 0; m_d[i] = 0;
            m_s0v[i] = 0; m_s0[i] = 0; m_s1v[i] = 0; m_s1[i] = 0;
        end
    endtask

    task automatic model_update();
        logic rv [N];
        for (int i = 0; i < N; i++) rv[i] = m_rev(i);
        if (tr_valid) begin
            int t;
            t = b_idx(tr_pc);
            if (m_v[t] && m_tag[t] == b_tag(tr_pc) && m_a[t] == tr_addr && m_d[t] == tr_data) begin
                if (m_c[t] < 3) m_c[t]++;
                m_e[t] = (m_c[t] == 3);
            end else begin
                m_a[t] = tr_addr; m_d[t] = tr_data; m_c[t] = 0; m_e[t] = 0;
            end
            m_v[t] = 1; m_tag[t] = b_tag(tr_pc);
            m_s0v[t] = tr_src0_vld; m_s0[t] = tr_src0; m_s1v[t] = tr_src1_vld; m_s1[t] = tr_src1;
        end
        for (int i = 0; i < N; i++) if (rv[i]) begin m_e[i] = 0; m_c[i] = 0; end
    endtask

    task automatic check(input string req, input logic act_h, input logic exp_h,
                         input logic [63:0] act_d, input logic [63:0] exp_d);
        checks++;
        if (act_h !== exp_h || act_d !== exp_d) begin
            fails++;
            $display("FAIL %s: hit=%0b data=%h expected hit=%0b data=%h", req, act_h, act_d, exp_h, exp_d);
        end
    endtask

    task automatic quiet();
        lk_valid = 0; tr_valid = 0; rw_valid = 0; st_valid = 0; sn_valid = 0;
    endtask

    // one cycle: inputs already driven at negedge
    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        quiet();
    endtask

    task automatic look(input logic [31:0] pc, input logic eh, input logic [63:0] ed, input string req);
        lk_valid = 1; lk_pc = pc;
        #1;
        check(req, lk_hit, eh, lk_data, eh ? ed : 64'd0);
        tick();
    endtask

    task automatic set_train(input logic [31:0] pc, input logic [31:0] a, input logic [63:0] d,
                             input logic [4:0] s0, input logic [4:0] s1);
        tr_valid = 1; tr_pc = pc; tr_addr = a; tr_data = d;
        tr_src0_vld = 1; tr_src0 = s0; tr_src1_vld = 1; tr_src1 = s1;
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] a, input logic [63:0] d,
                         input logic [4:0] s0, input logic [4:0] s1, input int n);
        for (int k = 0; k < n; k++) begin
            set_train(pc, a, d, s0, s1);
            tick();
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    localparam logic [31:0] PA = 32'h1000_0040;
    localparam logic [31:0] PB = 32'h1000_00C0; // same index as PA, other tag
    localparam logic [31:0] PC2 = 32'h1000_0044;
    localparam logic [31:0] XA = 32'h2000_0100;
    localparam logic [31:0] XC = 32'h2000_0200;
    localparam logic [63:0] DA = 64'hCAFE_0000_1234_5678;
    localparam logic [63:0] DC = 64'h0BAD_F00D_0000_0001;

    initial begin
        model_clear();
        quiet();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: nothing hits after reset
        look(PA, 0, 0, "R1");
        look(32'hFFFF_FFFC, 0, 0, "R1");

        // R2: three identical completions are not enough, the fourth is
        train(PA, XA, DA, 5'd3, 5'd4, 3);
        look(PA, 0, 0, "R2");
        train(PA, XA, DA, 5'd3, 5'd4, 1);
        look(PA, 1, DA, "R2/R3");

        // R10: same index, different tag
        look(PB, 0, 0, "R10");

        // R8 then R5: register write to the second source during lookup
        rw_valid = 1; rw_reg = 5'd4;
        look(PA, 0, 0, "R8");
        look(PA, 0, 0, "R5");

        // R9: retraining from kept data takes three events
        train(PA, XA, DA, 5'd3, 5'd4, 2);
        look(PA, 0, 0, "R9");
        train(PA, XA, DA, 5'd3, 5'd4, 1);
        look(PA, 1, DA, "R9");

        // R6: neighbouring block ignored, same block revokes
        st_valid = 1; st_addr = XA + 32'd8;
        tick();
        look(PA, 1, DA, "R6 other block");
        st_valid = 1; st_addr = XA + 32'd5;
        tick();
        look(PA, 0, 0, "R6 same block");

        // R7: snoop
        train(PA, XA, DA, 5'd3, 5'd4, 3);
        look(PA, 1, DA, "R7 before snoop");
        sn_valid = 1; sn_addr = XA + 32'd7;
        tick();
        look(PA, 0, 0, "R7");

        // R4: data change resets and records new value
        train(PA, XA, DA, 5'd3, 5'd4, 3);
        look(PA, 1, DA, "R4 before");
        train(PA, XA, DA + 64'd1, 5'd3, 5'd4, 1);
        look(PA, 0, 0, "R4 mismatch");
        train(PA, XA, DA + 64'd1, 5'd3, 5'd4, 2);
        look(PA, 0, 0, "R4 partial");
        train(PA, XA, DA + 64'd1, 5'd3, 5'd4, 1);
        look(PA, 1, DA + 64'd1, "R4 retrained");

        // R11: training and revocation together
        set_train(PA, XA, DA + 64'd1, 5'd3, 5'd4);
        rw_valid = 1; rw_reg = 5'd3;
        tick();
        look(PA, 0, 0, "R11");

        // R5: one write revokes two entries at once
        train(PA, XA, DA + 64'd1, 5'd3, 5'd4, 3);
        train(PC2, XC, DC, 5'd3, 5'd9, 4);
        look(PA, 1, DA + 64'd1, "R5 pre A");
        look(PC2, 1, DC, "R5 pre C");
        rw_valid = 1; rw_reg = 5'd3;
        tick();
        look(PA, 0, 0, "R5 A");
        look(PC2, 0, 0, "R5 C");

        // random phase against bench reference
        void'($urandom(32'd12345));
        for (int cyc = 0; cyc < 4000; cyc++) begin
            logic [31:0] pcs [4];
            logic [63:0] eh_d;
            int j;
            pcs[0] = PA; pcs[1] = PB; pcs[2] = PC2; pcs[3] = 32'h1000_0048;
            lk_valid = 1; lk_pc = pcs[$urandom % 4];
            if ($urandom % 4 != 0) begin
                j = $urandom % 4;
                set_train(pcs[j], ($urandom % 6 == 0) ? XC : XA + 32'(j * 64),
                          ($urandom % 8 == 0) ? DC : DA + 64'(j),
                          5'($urandom % 8), 5'($urandom % 8));
            end
            rw_valid = ($urandom % 16 == 0); rw_reg = 5'($urandom % 8);
            st_valid = ($urandom % 24 == 0); st_addr = XA + 32'($urandom % 256);
            sn_valid = ($urandom % 32 == 0); sn_addr = XA + 32'($urandom % 256);
            #1;
            eh_d = m_hit() ? m_d[b_idx(lk_pc)] : 64'd0;
            check("R3 random", lk_hit, m_hit(), lk_data, eh_d);
            tick();
        end

        // R1: reset again in the middle of use
        rst = 1;
        tick();
        rst = 0;
        model_clear();
        look(PA, 0, 0, "R1 rereset");

        summary();
        $finish;
    end
endmodule